// File: doc/BRIEF.md
# Set-Associative Word Cache Controller

This block sits between a processor's request port and a slower main-memory port. It holds single 32-bit words. A processor byte address loses its two low bits. The word address is then split into a set index, taken from its low bits, and a tag, taken from the rest. Every way of the selected set is compared at once. A match returns the stored word without touching memory. A miss goes to memory through a request/acknowledge handshake, and the processor stays stalled until the memory acknowledges.

Parameters choose the number of ways and the index width. They also choose what a write does. On a hit, a write can go to memory at once or only mark the entry dirty. On a miss, a write can install the word in the cache or go straight to memory. Each set keeps a cyclic victim pointer, and an empty way is always filled first. A flush request walks every entry, writes back every dirty word, and then signals completion.

Top module: `assoc_wcache`

## Requirements
- R1: After reset no entry is valid, and `cpu_ready`, `flush_done` and `mem_req` are low. The first access to any address is therefore a miss.
- R2: A read miss issues exactly one memory read at the word-aligned address. The returned word is installed and given back on `cpu_rdata` while `cpu_ready` is high. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ack`.
- R3: On a read hit, `cpu_ready` is high for exactly one cycle, in the cycle after the request is sampled. It carries the stored word, and no memory access takes place.
- R4: Address bits [1:0] are ignored, so addresses that differ only in those bits reach the same word. Every memory address has bits [1:0] equal to zero.
- R5: The victim is chosen as follows:
  - If any way of the set is invalid, the lowest-numbered invalid way is the victim.
  - Otherwise the victim is the set's pointer, which starts at way 0.
  - Installing into way w sets the pointer to (w+1) mod WAYS.
  - Hits leave the pointer unchanged.
- R6: In copy-back mode (`COPY_BACK=1`), a write hit updates only the cache and marks the entry dirty, and it answers in the cycle after the request. When a dirty entry is chosen as victim, it is first written to its own address.
- R7: In write-through mode (`COPY_BACK=0`), a write hit updates the cache and issues one memory write of the same word. `cpu_ready` follows that write's acknowledge.
- R8: With write-allocate (`WR_ALLOC=1`), a write miss installs the written word in the victim way without any memory read. A dirty victim is written back first, and the write-hit policy then applies.
- R9: With write-around (`WR_ALLOC=0`), a write miss performs one memory write and leaves the cache unchanged. A later read of that address therefore misses and returns the memory value.
- R10: A flush writes each valid dirty entry to memory exactly once and clears its dirty bit. It then raises `flush_done` for one cycle. A second flush with no writes in between issues no memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` |
| flush_req | input | 1 | Start a flush (sampled when idle) |
| flush_done | output | 1 | One-cycle pulse at flush end |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |

## Verification
The bench builds two instances, both with two ways and a two-bit index, so that four sets make conflict misses easy to force with a few addresses 16 bytes apart. The first instance uses copy-back with write-allocate, which brings dirty marking, evictions before refills, allocation on write and flush write-backs within reach. The second uses write-through with write-around, which exposes the immediate memory writes and write misses that bypass the cache. The memory model acknowledges after a fixed wait and counts reads and writes per access, so missing or extra traffic is seen directly.

// File: rtl/assoc_wcache.sv
module assoc_wcache #(
  parameter int WAYS      = 2,
  parameter int IDX_W     = 6,
  parameter bit COPY_BACK = 1'b1,
  parameter bit WR_ALLOC  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  input  logic        flush_req,
  output logic        flush_done,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = 30 - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RESP, S_EVICT, S_FETCH, S_WMEM, S_FSCAN, S_FWB, S_FDONE
  } st_t;

  st_t st;

  logic [31:0]      data_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  val_q   [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAY_W-1:0] rr_q    [SETS];

  logic [WAY_W-1:0] vway_q, hit_way, vic_way, ins_way;
  logic [IDX_W-1:0] fidx_q;
  logic [WAY_W-1:0] fway_q;
  logic [31:0]      rdata_q, ins_data;
  logic             hit, vic_dirty, ins_en, ins_fill;

  wire [IDX_W-1:0] idx = cpu_addr[IDX_W+1:2];
  wire [TAG_W-1:0] tag = cpu_addr[31:IDX_W+2];
  wire unused_lsb = ^cpu_addr[1:0];

  wire start      = (st == S_IDLE) && !flush_req && cpu_req;
  wire f_last_way = (fway_q == WAY_W'(WAYS - 1));
  wire f_last     = f_last_way && (fidx_q == IDX_W'(SETS - 1));
  wire f_dirty    = val_q[fidx_q][fway_q] && dirty_q[fidx_q][fway_q];

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (val_q[idx][w] && tag_q[idx][w] == tag) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    vic_way = rr_q[idx];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!val_q[idx][w]) vic_way = WAY_W'(w);
    end
    vic_dirty = val_q[idx][vic_way] && dirty_q[idx][vic_way];
  end

  always_comb begin
    ins_en = 1'b0;
    ins_fill = 1'b0;
    ins_way = vway_q;
    ins_data = cpu_wdata;
    if (start && cpu_we && hit) begin
      ins_en = 1'b1;
      ins_way = hit_way;
    end else if (start && cpu_we && WR_ALLOC && !vic_dirty) begin
      ins_en = 1'b1;
      ins_fill = 1'b1;
      ins_way = vic_way;
    end else if (st == S_EVICT && mem_ack && cpu_we) begin
      ins_en = 1'b1;
      ins_fill = 1'b1;
    end else if (st == S_FETCH && mem_ack) begin
      ins_en = 1'b1;
      ins_fill = 1'b1;
      ins_data = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      data_q[idx][ins_way] <= ins_data;
      tag_q[idx][ins_way]  <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vway_q  <= '0;
      rdata_q <= '0;
      fidx_q  <= '0;
      fway_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        val_q[s]   <= '0;
        dirty_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      if (ins_en) begin
        val_q[idx][ins_way]   <= 1'b1;
        dirty_q[idx][ins_way] <= COPY_BACK && cpu_we;
      end
      if (ins_fill)
        rr_q[idx] <= (ins_way == WAY_W'(WAYS - 1)) ? '0 : ins_way + 1'b1;

      case (st)
        S_IDLE: begin
          if (flush_req) begin
            fidx_q <= '0;
            fway_q <= '0;
            st     <= S_FSCAN;
          end else if (cpu_req) begin
            vway_q <= vic_way;
            if (hit) begin
              rdata_q <= data_q[idx][hit_way];
              st <= (cpu_we && !COPY_BACK) ? S_WMEM : S_RESP;
            end else if (cpu_we && !WR_ALLOC) st <= S_WMEM;
            else if (vic_dirty)               st <= S_EVICT;
            else if (cpu_we)                  st <= COPY_BACK ? S_RESP : S_WMEM;
            else                              st <= S_FETCH;
          end
        end
        S_RESP: st <= S_IDLE;
        S_EVICT: if (mem_ack) st <= !cpu_we ? S_FETCH : (COPY_BACK ? S_RESP : S_WMEM);
        S_FETCH: if (mem_ack) begin
          rdata_q <= mem_rdata;
          st <= S_RESP;
        end
        S_WMEM: if (mem_ack) st <= S_RESP;
        S_FSCAN: begin
          if (f_dirty) st <= S_FWB;
          else begin
            fway_q <= f_last_way ? '0 : fway_q + 1'b1;
            if (f_last_way) fidx_q <= fidx_q + 1'b1;
            st <= f_last ? S_FDONE : S_FSCAN;
          end
        end
        S_FWB: if (mem_ack) begin
          dirty_q[fidx_q][fway_q] <= 1'b0;
          fway_q <= f_last_way ? '0 : fway_q + 1'b1;
          if (f_last_way) fidx_q <= fidx_q + 1'b1;
          st <= f_last ? S_FDONE : S_FSCAN;
        end
        S_FDONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready  = (st == S_RESP);
  assign cpu_rdata  = rdata_q;
  assign flush_done = (st == S_FDONE);
  assign mem_req    = (st == S_EVICT) || (st == S_FETCH) || (st == S_WMEM) || (st == S_FWB);
  assign mem_we     = (st != S_FETCH);

  always_comb begin
    case (st)
      S_EVICT: begin
        mem_addr  = {tag_q[idx][vway_q], idx, 2'b00};
        mem_wdata = data_q[idx][vway_q];
      end
      S_FWB: begin
        mem_addr  = {tag_q[fidx_q][fway_q], fidx_q, 2'b00};
        mem_wdata = data_q[fidx_q][fway_q];
      end
      default: begin
        mem_addr  = {cpu_addr[31:2], 2'b00};
        mem_wdata = cpu_wdata;
      end
    endcase
  end
endmodule

// File: rtl/assoc_wcache_chk.sv
module assoc_wcache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_ready,
  input logic        flush_done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r3_ready_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ready) |-> $past(cpu_req));

  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !mem_req && !cpu_ready);
endmodule

bind assoc_wcache assoc_wcache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .flush_done(flush_done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/assoc_wcache_tb.sv
module assoc_wcache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cpu_req [2], cpu_we [2], flush_req [2];
  logic [31:0] cpu_addr [2], cpu_wdata [2];
  logic        cpu_ready [2], flush_done [2];
  logic [31:0] cpu_rdata [2];
  logic        mem_req [2], mem_we [2], mem_ack [2];
  logic [31:0] mem_addr [2], mem_wdata [2], mem_rdata [2];

  logic [31:0] mem_q [2][64];
  int          lat [2], rd_cnt [2], wr_cnt [2];
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  assoc_wcache #(.WAYS(2), .IDX_W(2), .COPY_BACK(1'b1), .WR_ALLOC(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
    .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
    .cpu_rdata(cpu_rdata[0]), .flush_req(flush_req[0]), .flush_done(flush_done[0]),
    .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
    .mem_wdata(mem_wdata[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]));

  assoc_wcache #(.WAYS(2), .IDX_W(2), .COPY_BACK(1'b0), .WR_ALLOC(1'b0)) u_dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
    .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
    .cpu_rdata(cpu_rdata[1]), .flush_req(flush_req[1]), .flush_done(flush_done[1]),
    .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
    .mem_wdata(mem_wdata[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]));

  assign mem_rdata[0] = mem_q[0][mem_addr[0][7:2]];
  assign mem_rdata[1] = mem_q[1][mem_addr[1][7:2]];

  always_ff @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        mem_ack[m] <= 1'b0;
        lat[m]     <= 0;
        rd_cnt[m]  <= 0;
        wr_cnt[m]  <= 0;
        for (int i = 0; i < 64; i++) mem_q[m][i] <= 32'hC0DE_0000 + 32'(i * 4);
      end else begin
        mem_ack[m] <= 1'b0;
        if (mem_req[m] && !mem_ack[m]) begin
          if (lat[m] == 2) begin
            mem_ack[m] <= 1'b1;
            lat[m] <= 0;
            if (mem_we[m]) begin
              mem_q[m][mem_addr[m][7:2]] <= mem_wdata[m];
              wr_cnt[m] <= wr_cnt[m] + 1;
            end else rd_cnt[m] <= rd_cnt[m] + 1;
          end else lat[m] <= lat[m] + 1;
        end
      end
    end
  end

  typedef struct packed {
    logic        d;
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  dr;
    logic [3:0]  dw;
    logic [3:0]  cyc;
    logic [7:0]  rq;
  } vec_t;

  // d0: copy-back + allocate; d1: write-through + around; set index = addr[3:2]
  localparam vec_t VEC [19] = '{
    '{1'b0, 1'b0, 32'h00, 32'h0,        32'hC0DE0000, 4'd1, 4'd0, 4'd0, 8'd1},  // R1 first read misses
    '{1'b0, 1'b0, 32'h03, 32'h0,        32'hC0DE0000, 4'd0, 4'd0, 4'd1, 8'd4},  // R4 offset ignored, R3 hit
    '{1'b0, 1'b0, 32'h10, 32'h0,        32'hC0DE0010, 4'd1, 4'd0, 4'd0, 8'd2},  // R2 fill way1
    '{1'b0, 1'b1, 32'h10, 32'h11111111, 32'h0,        4'd0, 4'd0, 4'd1, 8'd6},  // R6 write hit, cache only
    '{1'b0, 1'b0, 32'h20, 32'h0,        32'hC0DE0020, 4'd1, 4'd0, 4'd0, 8'd5},  // R5 victim way0 clean
    '{1'b0, 1'b0, 32'h30, 32'h0,        32'hC0DE0030, 4'd1, 4'd1, 4'd0, 8'd6},  // R6 dirty way1 evicted
    '{1'b0, 1'b0, 32'h10, 32'h0,        32'h11111111, 4'd1, 4'd0, 4'd0, 8'd6},  // R6 written-back value
    '{1'b0, 1'b0, 32'h20, 32'h0,        32'hC0DE0020, 4'd1, 4'd0, 4'd0, 8'd5},  // R5 cyclic picks way1
    '{1'b0, 1'b0, 32'h10, 32'h0,        32'h11111111, 4'd0, 4'd0, 4'd1, 8'd5},  // R5 way0 kept
    '{1'b0, 1'b1, 32'h04, 32'h22222222, 32'h0,        4'd0, 4'd0, 4'd1, 8'd8},  // R8 allocate, no fetch
    '{1'b0, 1'b0, 32'h04, 32'h0,        32'h22222222, 4'd0, 4'd0, 4'd1, 8'd8},  // R8 allocated word hits
    '{1'b0, 1'b1, 32'h14, 32'h33333333, 32'h0,        4'd0, 4'd0, 4'd1, 8'd8},
    '{1'b0, 1'b1, 32'h24, 32'h44444444, 32'h0,        4'd0, 4'd1, 4'd0, 8'd8},  // R8 dirty victim first
    '{1'b0, 1'b0, 32'h04, 32'h0,        32'h22222222, 4'd1, 4'd1, 4'd0, 8'd6},
    '{1'b1, 1'b0, 32'h08, 32'h0,        32'hC0DE0008, 4'd1, 4'd0, 4'd0, 8'd2},
    '{1'b1, 1'b1, 32'h08, 32'h55555555, 32'h0,        4'd0, 4'd1, 4'd0, 8'd7},  // R7 write-through hit
    '{1'b1, 1'b0, 32'h08, 32'h0,        32'h55555555, 4'd0, 4'd0, 4'd1, 8'd7},  // R7 cache updated too
    '{1'b1, 1'b1, 32'h18, 32'h66666666, 32'h0,        4'd0, 4'd1, 4'd0, 8'd9},  // R9 write-around
    '{1'b1, 1'b0, 32'h18, 32'h0,        32'h66666666, 4'd1, 4'd0, 4'd0, 8'd9}   // R9 cache unchanged
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic access(input int d, input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc, output int dr, output int dw);
    int r0, w0;
    r0 = rd_cnt[d];
    w0 = wr_cnt[d];
    cpu_req[d] = 1'b1; cpu_we[d] = we; cpu_addr[d] = a; cpu_wdata[d] = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready[d] && cyc < 60);
    if (!cpu_ready[d]) cyc = -1;
    rd = cpu_rdata[d];
    cpu_req[d] = 1'b0;
    dr = rd_cnt[d] - r0;
    dw = wr_cnt[d] - w0;
  endtask

  task automatic flush(input int d, output int cyc, output int dw);
    int w0;
    w0 = wr_cnt[d];
    flush_req[d] = 1'b1;
    @(negedge clk);
    flush_req[d] = 1'b0;
    cyc = 1;
    while (!flush_done[d] && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    if (!flush_done[d]) cyc = -1;
    dw = wr_cnt[d] - w0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc, dr, dw;
    string rq;
    for (int d = 0; d < 2; d++) begin
      cpu_req[d] = 1'b0; cpu_we[d] = 1'b0; flush_req[d] = 1'b0;
      cpu_addr[d] = '0; cpu_wdata[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(!cpu_ready[d], "R1", "ready after reset", 32'(cpu_ready[d]), 32'd0);
      chk(!mem_req[d], "R1", "mem_req after reset", 32'(mem_req[d]), 32'd0);
      chk(!flush_done[d], "R1", "flush_done after reset", 32'(flush_done[d]), 32'd0);
    end

    for (int i = 0; i < 19; i++) begin
      rq = $sformatf("R%0d", VEC[i].rq);
      access(int'(VEC[i].d), VEC[i].we, VEC[i].addr, VEC[i].wdata, rd, cyc, dr, dw);
      chk(cyc != -1, rq, $sformatf("vec %0d completes", i), 32'(cyc), 32'd1);
      if (!VEC[i].we) chk(rd == VEC[i].exp, rq, $sformatf("vec %0d rdata", i), rd, VEC[i].exp);
      chk(dr == int'(VEC[i].dr), rq, $sformatf("vec %0d mem reads", i), 32'(dr), 32'(VEC[i].dr));
      chk(dw == int'(VEC[i].dw), rq, $sformatf("vec %0d mem writes", i), 32'(dw), 32'(VEC[i].dw));
      if (VEC[i].cyc != 0) chk(cyc == int'(VEC[i].cyc), rq, $sformatf("vec %0d latency", i), 32'(cyc), 32'(VEC[i].cyc));
      @(negedge clk);
      chk(!cpu_ready[VEC[i].d], "R3", $sformatf("vec %0d ready one cycle", i), 32'(cpu_ready[VEC[i].d]), 32'd0);
    end

    // R6 and R7: memory contents after eviction and write-through
    chk(mem_q[0][4] == 32'h11111111, "R6", "evicted word in memory", mem_q[0][4], 32'h11111111);
    chk(mem_q[0][5] == 32'h33333333, "R6", "second evicted word", mem_q[0][5], 32'h33333333);
    chk(mem_q[1][2] == 32'h55555555, "R7", "write-through word", mem_q[1][2], 32'h55555555);
    chk(mem_q[1][6] == 32'h66666666, "R9", "write-around word", mem_q[1][6], 32'h66666666);

    // R10: flush of copy-back instance, only 0x24 is dirty
    chk(mem_q[0][9] == 32'hC0DE0024, "R10", "0x24 stale before flush", mem_q[0][9], 32'hC0DE0024);
    flush(0, cyc, dw);
    chk(cyc != -1, "R10", "flush done seen", 32'(cyc), 32'd1);
    chk(dw == 1, "R10", "flush writes", 32'(dw), 32'd1);
    chk(mem_q[0][9] == 32'h44444444, "R10", "flushed word", mem_q[0][9], 32'h44444444);
    @(negedge clk);
    chk(!flush_done[0], "R10", "done is one cycle", 32'(flush_done[0]), 32'd0);
    flush(0, cyc, dw);
    chk(dw == 0, "R10", "second flush writes", 32'(dw), 32'd0);
    @(negedge clk);
    access(0, 1'b0, 32'h24, 32'h0, rd, cyc, dr, dw);
    chk(rd == 32'h44444444 && dr == 0, "R10", "entry stays valid after flush", rd, 32'h44444444);
    @(negedge clk);
    flush(1, cyc, dw);
    chk(cyc != -1 && dw == 0, "R7", "write-through flush writes", 32'(dw), 32'd0);
    @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule